// File: doc/BRIEF.md
# Accumulator Arithmetic-Logic Unit with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit machine that works around an accumulator. For each accepted operation it reads five things: an operation code, the accumulator byte, one operand byte, the current flag byte and a bit that says whether the operand came from an immediate field. It then produces the new accumulator value, a byte to be written back to memory, the new flag byte and the number of T-states the operation consumes. Instruction decode, register-file selection and memory access belong to the surrounding core. The operand byte is whatever that core fetched, either a register or the byte at the memory pointer.

The operations are AND, OR and XOR, add with carry, subtract with borrow, two's-complement negate, and a set of rotates and shifts. The rotates and shifts are rotate-right through carry, rotate-left circular, shift-right logical, and a nibble rotate that spreads its work across the accumulator and a memory byte. Every operation has its own rule for each flag. One registered stage holds the outputs, so the core sees a result one clock after it presents an operation. Those outputs stay unchanged until the next accepted operation.

Top module: `acc_alu`

## Requirements
- R1: The flag byte is laid out as S=bit 7, Z=bit 6, H=bit 4, PV=bit 2, N=bit 1 and C=bit 0. Operation codes 0, 1 and 2 are AND, OR and XOR of accumulator and operand. They clear C and N, set Z for a zero result, copy result bit 7 to S and set PV when the result holds an even number of ones. H becomes 1 after AND and 0 after OR or XOR.
- R2: Code 3 adds accumulator, operand and incoming C (for example 0x22 + 0x77 with C=0 gives 0x99). C is the carry out of bit 7, H is the carry out of bit 3, PV is signed overflow and N is 0. S and Z follow the result.
- R3: Code 4 subtracts the operand and incoming C from the accumulator (for example 0x40 - 0x3F with C=0 gives 0x01). C is the borrow out of bit 7, H is the borrow out of bit 3, PV is signed overflow and N is 1. S and Z follow the result.
- R4: Code 5 negates the accumulator (0 minus A). N is set. C is set when A was nonzero. H is set when A's low nibble was nonzero. PV is set only when A was 0x80. S and Z follow the result.
- R5: Code 6 rotates the accumulator right through carry: old bit 0 goes to C and old C goes to bit 7. H and N are cleared, and S, Z and PV are left unchanged.
- R6: Code 7 rotates the accumulator left circularly: old bit 7 goes to both C and bit 0. H and N are cleared, and S, Z and PV are left unchanged.
- R7: Code 8 shifts the accumulator right with a 0 entering bit 7. Old bit 0 goes to C. S, H and N are cleared, Z follows the result and PV gets even parity.
- R8: Code 9 is the nibble rotate with the operand as the memory byte. The new accumulator keeps its high nibble and takes the memory byte's low nibble. The memory output carries the old accumulator low nibble in bits 7:4 and the old memory high nibble in bits 3:0. S, Z and PV (parity) come from the new accumulator, H and N are cleared, and C is unchanged.
- R9: T-state count is 4 for codes 0 to 4 with a register operand and 7 for codes 0 to 4 with an immediate operand. It is 8 for codes 5 and 8, 4 for codes 6 and 7, and 18 for code 9. The immediate bit has no effect on the other codes.
- R10: Flag bits 5 and 3 are always copied from the incoming flag byte.
- R11: Outputs appear one clock after an operation is accepted with in_valid high, and out_valid is high for exactly those cycles. Cycles with in_valid low leave every data output unchanged.
- R12: While reset is asserted, every output is zero. Reset takes effect at once and is released on a clock edge.
- R13: Codes 10 to 15 return the accumulator unchanged, pass the operand to the memory output, leave the flags unchanged and report 4 T-states.
- R14: For every code except 9, the memory output equals the operand byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the operation presented this cycle |
| op_code | input | 4 | Operation selector (codes listed in the requirements) |
| src_imm | input | 1 | Operand came from an immediate field (affects T-states only) |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Operand byte or memory byte |
| flags_in | input | 8 | Current flag byte |
| out_valid | output | 1 | Registered result is new this cycle |
| res_out | output | 8 | New accumulator value |
| mem_out | output | 8 | Byte to write back to memory |
| flags_out | output | 8 | New flag byte |
| tstates_out | output | 5 | T-states taken by the operation |

## Verification
The assertions assume that op_code, acc_in, opnd_in, flags_in and src_imm are known and steady around the clock edge at which in_valid is high. They also assume in_valid stays low until the internal reset release has completed. The bench keeps to this by driving every input on the falling edge only. It also waits several cycles after reset release before raising in_valid. The stimulus mixes directed corner cases with random codes, data and gaps in in_valid, including the undefined codes.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DATA_W = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int TS_W   = 5;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_ADC  = 4'd3,
    OP_SBC  = 4'd4,
    OP_NEG  = 4'd5,
    OP_RRA  = 4'd6,
    OP_RLCA = 4'd7,
    OP_SRL  = 4'd8,
    OP_RRD  = 4'd9
  } alu_op_e;

  // flag byte bit positions
  localparam int FB_C  = 0;
  localparam int FB_N  = 1;
  localparam int FB_PV = 2;
  localparam int FB_H  = 4;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;

  localparam logic [TS_W-1:0] TS_REG  = TS_W'(4);
  localparam logic [TS_W-1:0] TS_IMM  = TS_W'(7);
  localparam logic [TS_W-1:0] TS_PFX  = TS_W'(8);
  localparam logic [TS_W-1:0] TS_NIB  = TS_W'(18);

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic [DATA_W-1:0] mem;
    logic [7:0]        flags;
    logic [TS_W-1:0]   ts;
  } alu_out_t;
endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
(
  input  logic [1:0]        sel,     // 0 and, 1 or, 2 xor
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [7:0]        f_in,
  output logic [DATA_W-1:0] res,
  output logic [7:0]        f_out
);
  always_comb begin
    unique case (sel)
      2'd0:    res = a & b;
      2'd1:    res = a | b;
      default: res = a ^ b;
    endcase
    f_out        = f_in;
    f_out[FB_S]  = res[DATA_W-1];
    f_out[FB_Z]  = (res == '0);
    f_out[FB_H]  = (sel == 2'd0);
    f_out[FB_PV] = ~^res;
    f_out[FB_N]  = 1'b0;
    f_out[FB_C]  = 1'b0;
  end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
(
  input  logic              sub,     // subtract instead of add
  input  logic              neg,     // compute 0 - a, no carry in
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [7:0]        f_in,
  output logic [DATA_W-1:0] res,
  output logic [7:0]        f_out
);
  logic [DATA_W-1:0] x, y;
  logic              cin;
  logic [DATA_W:0]   full;
  logic [HALF_W:0]   half;
  logic              ovf;

  always_comb begin
    x   = neg ? '0 : a;
    y   = neg ? a  : b;
    cin = neg ? 1'b0 : f_in[FB_C];
    if (sub) begin
      full = {1'b0, x} - {1'b0, y} - (DATA_W+1)'(cin);
      half = {1'b0, x[HALF_W-1:0]} - {1'b0, y[HALF_W-1:0]} - (HALF_W+1)'(cin);
    end else begin
      full = {1'b0, x} + {1'b0, y} + (DATA_W+1)'(cin);
      half = {1'b0, x[HALF_W-1:0]} + {1'b0, y[HALF_W-1:0]} + (HALF_W+1)'(cin);
    end
    res = full[DATA_W-1:0];
    if (sub) ovf = (x[DATA_W-1] != y[DATA_W-1]) && (res[DATA_W-1] != x[DATA_W-1]);
    else     ovf = (x[DATA_W-1] == y[DATA_W-1]) && (res[DATA_W-1] != x[DATA_W-1]);
    f_out        = f_in;
    f_out[FB_S]  = res[DATA_W-1];
    f_out[FB_Z]  = (res == '0);
    f_out[FB_H]  = half[HALF_W];
    f_out[FB_PV] = ovf;
    f_out[FB_N]  = sub;
    f_out[FB_C]  = full[DATA_W];
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
(
  input  logic [1:0]        sel,     // 0 rra, 1 rlca, 2 srl, 3 nibble rotate
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] m,
  input  logic [7:0]        f_in,
  output logic [DATA_W-1:0] res,
  output logic [DATA_W-1:0] mem,
  output logic [7:0]        f_out
);
  always_comb begin
    res   = a;
    mem   = m;
    f_out = f_in;
    f_out[FB_H] = 1'b0;
    f_out[FB_N] = 1'b0;
    unique case (sel)
      2'd0: begin
        res         = {f_in[FB_C], a[DATA_W-1:1]};
        f_out[FB_C] = a[0];
      end
      2'd1: begin
        res         = {a[DATA_W-2:0], a[DATA_W-1]};
        f_out[FB_C] = a[DATA_W-1];
      end
      2'd2: begin
        res          = {1'b0, a[DATA_W-1:1]};
        f_out[FB_C]  = a[0];
        f_out[FB_S]  = 1'b0;
        f_out[FB_Z]  = (res == '0);
        f_out[FB_PV] = ~^res;
      end
      default: begin
        res          = {a[DATA_W-1:HALF_W], m[HALF_W-1:0]};
        mem          = {a[HALF_W-1:0], m[DATA_W-1:HALF_W]};
        f_out[FB_S]  = res[DATA_W-1];
        f_out[FB_Z]  = (res == '0);
        f_out[FB_PV] = ~^res;
      end
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_code,
  input  logic              src_imm,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic [7:0]        flags_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_out,
  output logic [DATA_W-1:0] mem_out,
  output logic [7:0]        flags_out,
  output logic [TS_W-1:0]   tstates_out
);
  // reset: asserted at once, released through a short flop chain
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_sync;

  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end
  endgenerate
  assign rst_n_sync = rst_pipe[SYNC_STAGES-1];

  // functional units
  logic [DATA_W-1:0] lg_res, ar_res, sh_res, sh_mem;
  logic [7:0]        lg_f, ar_f, sh_f;
  logic [1:0]        lg_sel, sh_sel;
  logic              ar_sub, ar_neg;
  alu_op_e           op;

  assign op = alu_op_e'(op_code);

  always_comb begin
    lg_sel = op_code[1:0];
    ar_sub = (op != OP_ADC);
    ar_neg = (op == OP_NEG);
    unique case (op)
      OP_RRA:  sh_sel = 2'd0;
      OP_RLCA: sh_sel = 2'd1;
      OP_SRL:  sh_sel = 2'd2;
      default: sh_sel = 2'd3;
    endcase
  end

  acc_alu_logic u_logic (
    .sel(lg_sel), .a(acc_in), .b(opnd_in), .f_in(flags_in),
    .res(lg_res), .f_out(lg_f)
  );

  acc_alu_arith u_arith (
    .sub(ar_sub), .neg(ar_neg), .a(acc_in), .b(opnd_in), .f_in(flags_in),
    .res(ar_res), .f_out(ar_f)
  );

  acc_alu_shift u_shift (
    .sel(sh_sel), .a(acc_in), .m(opnd_in), .f_in(flags_in),
    .res(sh_res), .mem(sh_mem), .f_out(sh_f)
  );

  // result selection
  alu_out_t d_sel, q_cur, q_next;
  logic     v_next;

  always_comb begin
    d_sel.res   = acc_in;
    d_sel.mem   = opnd_in;
    d_sel.flags = flags_in;
    d_sel.ts    = TS_REG;
    case (op)
      OP_AND, OP_OR, OP_XOR: begin
        d_sel.res   = lg_res;
        d_sel.flags = lg_f;
        d_sel.ts    = src_imm ? TS_IMM : TS_REG;
      end
      OP_ADC, OP_SBC: begin
        d_sel.res   = ar_res;
        d_sel.flags = ar_f;
        d_sel.ts    = src_imm ? TS_IMM : TS_REG;
      end
      OP_NEG: begin
        d_sel.res   = ar_res;
        d_sel.flags = ar_f;
        d_sel.ts    = TS_PFX;
      end
      OP_RRA, OP_RLCA: begin
        d_sel.res   = sh_res;
        d_sel.flags = sh_f;
      end
      OP_SRL: begin
        d_sel.res   = sh_res;
        d_sel.flags = sh_f;
        d_sel.ts    = TS_PFX;
      end
      OP_RRD: begin
        d_sel.res   = sh_res;
        d_sel.mem   = sh_mem;
        d_sel.flags = sh_f;
        d_sel.ts    = TS_NIB;
      end
      default: ;
    endcase
  end

  // next state: load on accept, otherwise hold
  always_comb begin
    q_next = in_valid ? d_sel : q_cur;
    v_next = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      q_cur     <= '0;
      out_valid <= 1'b0;
    end else begin
      q_cur     <= q_next;
      out_valid <= v_next;
    end
  end

  assign res_out     = q_cur.res;
  assign mem_out     = q_cur.mem;
  assign flags_out   = q_cur.flags;
  assign tstates_out = q_cur.ts;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [3:0] op_code,
  input logic [7:0] acc_in,
  input logic [7:0] opnd_in,
  input logic [7:0] flags_in,
  input logic       out_valid,
  input logic [7:0] res_out,
  input logic [7:0] mem_out,
  input logic [7:0] flags_out,
  input logic [4:0] tstates_out
);
  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(res_out) && $stable(mem_out)
                   && $stable(flags_out) && $stable(tstates_out)));

  // R1
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code <= 4'd2) |=> (!flags_out[0] && !flags_out[1]
      && flags_out[6] == (res_out == 8'h00) && flags_out[7] == res_out[7]
      && flags_out[2] == ~^res_out));

  // R1
  and_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 4'd0) |=> flags_out[4]);

  // R4
  negate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 4'd5) |=> (flags_out[1]
      && flags_out[0] == ($past(acc_in) != 8'h00)
      && res_out == 8'(8'h00 - $past(acc_in))));

  // R6
  rlca_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 4'd7) |=> (flags_out[0] == $past(acc_in[7])
      && res_out == {$past(acc_in[6:0]), $past(acc_in[7])}));

  // R8
  nibble_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 4'd9) |=>
      (res_out == {$past(acc_in[7:4]), $past(opnd_in[3:0])}
       && mem_out == {$past(acc_in[3:0]), $past(opnd_in[7:4])}));

  // R10
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (flags_out[5] == $past(flags_in[5])
                  && flags_out[3] == $past(flags_in[3])));

  // R9
  tstate_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (tstates_out inside {5'd4, 5'd7, 5'd8, 5'd18}));

  // R14
  mem_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code != 4'd9) |=> mem_out == $past(opnd_in));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n_sync), .in_valid(in_valid), .op_code(op_code),
  .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
  .out_valid(out_valid), .res_out(res_out), .mem_out(mem_out),
  .flags_out(flags_out), .tstates_out(tstates_out)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] op_code;
  logic       src_imm;
  logic [7:0] acc_in, opnd_in, flags_in;
  logic       out_valid;
  logic [7:0] res_out, mem_out, flags_out;
  logic [4:0] tstates_out;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int    exp_v, exp_r, exp_m, exp_f, exp_t;
  string exp_tag;

  always #2.5 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .src_imm(src_imm), .acc_in(acc_in), .opnd_in(opnd_in),
    .flags_in(flags_in), .out_valid(out_valid), .res_out(res_out),
    .mem_out(mem_out), .flags_out(flags_out), .tstates_out(tstates_out)
  );

  function automatic int even_par(int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2 == 0) ? 1 : 0;
  endfunction

  function automatic int sgn(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1, 2: return "R1";
      3: return "R2";
      4: return "R3";
      5: return "R4";
      6: return "R5";
      7: return "R6";
      8: return "R7";
      9: return "R8";
      default: return "R13";
    endcase
  endfunction

  // behavioural reference, flag byte S7 Z6 H4 PV2 N1 C0
  task automatic ref_model(input int op, a, b, f, imm,
                           output int r, m, nf, ts);
    int cin, s, h, ov, c, n;
    cin = f & 1;
    r = a; m = b; nf = f; ts = 4;
    case (op)
      0, 1, 2: begin
        r  = (op == 0) ? (a & b) : (op == 1) ? (a | b) : (a ^ b);
        nf = (f & 'h28) | ((r >= 128) ? 128 : 0) | ((r == 0) ? 64 : 0)
           | ((op == 0) ? 16 : 0) | (even_par(r) ? 4 : 0);
        ts = imm ? 7 : 4;
      end
      3, 4, 5: begin
        if (op == 3) begin
          s  = a + b + cin;
          h  = ((a % 16) + (b % 16) + cin) > 15;
          ov = (sgn(a) + sgn(b) + cin > 127) || (sgn(a) + sgn(b) + cin < -128);
          c  = s > 255; n = 0;
          ts = imm ? 7 : 4;
        end else if (op == 4) begin
          s  = a - b - cin;
          h  = ((a % 16) - (b % 16) - cin) < 0;
          ov = (sgn(a) - sgn(b) - cin > 127) || (sgn(a) - sgn(b) - cin < -128);
          c  = s < 0; n = 1;
          ts = imm ? 7 : 4;
        end else begin
          s  = 0 - a;
          h  = (a % 16) != 0;
          ov = (a == 128);
          c  = (a != 0); n = 1;
          ts = 8;
        end
        r  = (s + 512) % 256;
        nf = (f & 'h28) | ((r >= 128) ? 128 : 0) | ((r == 0) ? 64 : 0)
           | (h ? 16 : 0) | (ov ? 4 : 0) | (n ? 2 : 0) | (c ? 1 : 0);
      end
      6: begin
        r  = (a >> 1) | (cin << 7);
        nf = (f & 'hEC) | (a & 1);
      end
      7: begin
        r  = ((a << 1) & 255) | (a >> 7);
        nf = (f & 'hEC) | (a >> 7);
      end
      8: begin
        r  = a >> 1;
        nf = (f & 'h28) | ((r == 0) ? 64 : 0) | (even_par(r) ? 4 : 0) | (a & 1);
        ts = 8;
      end
      9: begin
        r  = (a & 'hF0) | (b & 'h0F);
        m  = ((a & 'h0F) << 4) | (b >> 4);
        nf = (f & 'h29) | ((r >= 128) ? 128 : 0) | ((r == 0) ? 64 : 0)
           | (even_par(r) ? 4 : 0);
        ts = 18;
      end
      default: ;
    endcase
  endtask

  task automatic chk(string tag, string what, int act, int expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic compare_all();
    chk("R11", "out_valid", int'(out_valid), exp_v);
    chk(exp_tag, "result", int'(res_out), exp_r);
    chk((exp_tag == "R8") ? "R8" : "R14", "memory byte", int'(mem_out), exp_m);
    chk(exp_tag, "flags", int'(flags_out) & 'hD7, exp_f & 'hD7);
    chk("R10", "spare flag bits", int'(flags_out) & 'h28, exp_f & 'h28);
    chk("R9", "tstates", int'(tstates_out), exp_t);
  endtask

  // one clock: check previous result, then present the next operation
  task automatic step(int v, int op, int a, int b, int f, int imm);
    @(negedge clk);
    compare_all();
    in_valid = v[0]; op_code = op[3:0]; acc_in = a[7:0];
    opnd_in = b[7:0]; flags_in = f[7:0]; src_imm = imm[0];
    exp_v = v;
    if (v != 0) begin
      ref_model(op, a, b, f, imm, exp_r, exp_m, exp_f, exp_t);
      exp_tag = tag_of(op);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; src_imm = 1'b0;
    acc_in = '0; opnd_in = '0; flags_in = '0;
    exp_v = 0; exp_r = 0; exp_m = 0; exp_f = 0; exp_t = 0; exp_tag = "R12";
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "out_valid in reset", int'(out_valid), 0);
    chk("R12", "result in reset", int'(res_out), 0);
    chk("R12", "flags in reset", int'(flags_out), 0);
    chk("R12", "tstates in reset", int'(tstates_out), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // directed corner cases
    step(1, 3, 'h22, 'h77, 'h00, 0);   // R2 0x22+0x77 -> 0x99
    step(1, 4, 'h40, 'h3F, 'h00, 1);   // R3 0x40-0x3F -> 0x01
    step(1, 5, 'h80, 'h00, 'h00, 0);   // R4 overflow case
    step(1, 5, 'h00, 'h00, 'hFF, 0);   // R4 zero operand
    step(1, 0, 'hF0, 'h0F, 'h00, 1);   // R1 AND zero result
    step(1, 1, 'h81, 'h02, 'h11, 0);   // R1 OR
    step(1, 2, 'h55, 'h55, 'h01, 0);   // R1 XOR
    step(0, 0, 'hAA, 'hAA, 'h00, 0);   // R11 idle holds
    step(1, 6, 'h01, 'h00, 'h00, 0);   // R5
    step(1, 6, 'h02, 'h00, 'hC5, 1);   // R5 carry into bit 7
    step(1, 7, 'h81, 'h00, 'h00, 0);   // R6
    step(1, 8, 'h01, 'h00, 'h80, 0);   // R7 zero result
    step(1, 9, 'h7A, 'hC3, 'h29, 0);   // R8
    step(1, 12, 'h5A, 'h3C, 'hA5, 1);  // R13
    step(1, 3, 'h7F, 'h00, 'h01, 0);   // R2 overflow with carry
    step(1, 4, 'h00, 'hFF, 'h01, 0);   // R3 widest borrow

    for (int i = 0; i < 2000; i++) begin
      int v, op;
      v  = ($urandom % 5 != 0) ? 1 : 0;
      op = $urandom % 16;
      step(v, op, $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 2);
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule